// File: doc/BRIEF.md
# Four-Mode Bidirectional Shift Register

This block is a small universal register of `WIDTH` bits (four by default). On each rising clock edge it does one of four things, picked by a two-bit mode code: it captures a parallel word, moves its contents one place toward the high index, moves them one place toward the low index, or keeps them unchanged. Each shift direction has its own serial input. The bit that enters on an upward shift goes into index 0. The bit that enters on a downward shift goes into the top index.

A low level on the clear input empties the register at once, with no clock edge needed, and holds it empty whatever the mode code says. No dedicated serial output pin exists. The top bit of the parallel output serves as the outgoing stream for upward shifts, and bit 0 serves for downward shifts. A user who wants rotation wires one of these bits back to the matching serial input outside the block.

Top module: `ushift_reg`

## Requirements
- R1: While `clr_n` is low, `q` reads all zeros. After reset is released, `q` stays zero until the first active mode edge.
- R2: With `mode` = 2'b11, the rising edge copies `d` into `q` bit for bit.
- R3: With `mode` = 2'b01, the rising edge sets `q[0]` to `sin_up` and each `q[i]` to the old `q[i-1]`. The old top bit is discarded.
- R4: With `mode` = 2'b10, the rising edge sets `q[WIDTH-1]` to `sin_dn` and each `q[i]` to the old `q[i+1]`. The old `q[0]` is discarded.
- R5: With `mode` = 2'b00, `q` keeps its value across the edge, whatever `d`, `sin_up` and `sin_dn` carry.
- R6: A falling `clr_n` zeroes `q` without waiting for a clock edge. While it stays low, clear wins over every mode, including load.
- R7: A new mode code takes effect at the very next rising edge. Changing the code on every cycle gives a different operation on each successive edge.
- R8: A bit fed in on `sin_up` appears on `q[WIDTH-1]` after WIDTH upward shifts. A bit fed in on `sin_dn` appears on `q[0]` after WIDTH downward shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Operation code: 00 hold, 01 shift up, 10 shift down, 11 load |
| d | input | WIDTH | Parallel data word |
| sin_up | input | 1 | Serial bit entering index 0 on upward shifts |
| sin_dn | input | 1 | Serial bit entering the top index on downward shifts |
| q | output | WIDTH | Register contents |

## Verification
Every mode result appears on `q` one edge after the inputs that request it, because only a single register stage lies between the inputs and `q`. The bench drives inputs at the falling edge. At that moment it queues the predicted word, and a monitor pops and compares it shortly after the next rising edge. Clear is the only result with no clock delay. It is checked a few nanoseconds after `clr_n` falls, before any edge, and again after an edge taken with load requested. The serial-latency check counts exactly WIDTH shift edges before it reads the end bit.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
   typedef enum logic [1:0] {
      OP_HOLD = 2'b00,
      OP_UP   = 2'b01,
      OP_DOWN = 2'b10,
      OP_LOAD = 2'b11
   } op_e;
endpackage

// File: rtl/ushift_decode.sv
module ushift_decode
   import ushift_pkg::*;
(
   input  logic [1:0] sel,
   output op_e        op
);
   always_comb begin
      unique case (sel)
         2'b01:   op = OP_UP;
         2'b10:   op = OP_DOWN;
         2'b11:   op = OP_LOAD;
         default: op = OP_HOLD;
      endcase
   end
endmodule

// File: rtl/ushift_cell.sv
module ushift_cell
   import ushift_pkg::*;
(
   input  op_e  op,
   input  logic self_q,
   input  logic from_lo,
   input  logic from_hi,
   input  logic par,
   output logic nxt
);
   always_comb begin
      unique case (op)
         OP_UP:   nxt = from_lo;
         OP_DOWN: nxt = from_hi;
         OP_LOAD: nxt = par;
         default: nxt = self_q;
      endcase
   end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
   import ushift_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [1:0]       mode,
   input  logic [WIDTH-1:0] d,
   input  logic             sin_up,
   input  logic             sin_dn,
   output logic [WIDTH-1:0] q
);
   localparam int TOP = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("ushift_reg: WIDTH must be at least 2");
      end
   endgenerate

   op_e              op;
   logic [WIDTH-1:0] q_nxt;

   ushift_decode u_dec (
      .sel (mode),
      .op  (op)
   );

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         logic lo_src, hi_src;
         if (gi == 0) begin : g_lo_edge
            assign lo_src = sin_up;
         end else begin : g_lo_mid
            assign lo_src = q[gi-1];
         end
         if (gi == TOP) begin : g_hi_edge
            assign hi_src = sin_dn;
         end else begin : g_hi_mid
            assign hi_src = q[gi+1];
         end
         ushift_cell u_cell (
            .op      (op),
            .self_q  (q[gi]),
            .from_lo (lo_src),
            .from_hi (hi_src),
            .par     (d[gi]),
            .nxt     (q_nxt[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) q <= '0;
      else        q <= q_nxt;
   end

   always @(posedge clk) begin
      if (!clr_n) AST_CLEAR_ZERO: assert (q == '0); // R1
   end

   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!clr_n)
      (mode == 2'b11) |=> (q == $past(d))); // R2

   AST_UP_MOVE: assert property (@(posedge clk) disable iff (!clr_n)
      (mode == 2'b01) |=> (q[0] == $past(sin_up)) && (q[TOP:1] == $past(q[TOP-1:0]))); // R3

   AST_DOWN_MOVE: assert property (@(posedge clk) disable iff (!clr_n)
      (mode == 2'b10) |=> (q[TOP] == $past(sin_dn)) && (q[TOP-1:0] == $past(q[TOP:1]))); // R4

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
      (mode == 2'b00) |=> $stable(q)); // R5
endmodule

// File: tb/tb_ushift_reg.sv
`timescale 1ns/1ps
module tb_ushift_reg;
   localparam int W = 4;

   typedef struct {
      logic [W-1:0] val;
      string        req;
   } exp_t;

   logic         clk = 1'b0;
   logic         clr_n;
   logic [1:0]   mode;
   logic [W-1:0] d;
   logic         sin_up, sin_dn;
   logic [W-1:0] q;

   int total = 0;
   int bad   = 0;
   exp_t         sb[$];
   logic [W-1:0] model;
   bit           done = 1'b0;

   ushift_reg #(.WIDTH(W)) dut (
      .clk(clk), .clr_n(clr_n), .mode(mode), .d(d),
      .sin_up(sin_up), .sin_dn(sin_dn), .q(q)
   );

   always #4 clk = ~clk;

   task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: q=%b expected %b", req, act, exp);
      end
   endtask

   // monitor: compares one queued item just after each rising edge
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(q, e.val, e.req);
      end
   end

   // driver: sets inputs at the falling edge and queues the prediction
   task automatic step(input logic [1:0] m, input logic [W-1:0] dv,
                       input logic su, input logic sd, input string req);
      exp_t e;
      @(negedge clk);
      mode = m; d = dv; sin_up = su; sin_dn = sd;
      case (m)
         2'b11: model = dv;
         2'b01: model = {model[W-2:0], su};
         2'b10: model = {sd, model[W-1:1]};
         default: model = model;
      endcase
      e.val = model; e.req = req;
      sb.push_back(e);
   endtask

   initial begin
      clr_n = 1'b0; mode = 2'b11; d = 4'b1111; sin_up = 1'b1; sin_dn = 1'b1;
      model = '0;
      repeat (2) @(posedge clk);
      #1 check(q, 4'b0000, "R1 reset");
      @(negedge clk); clr_n = 1'b1; mode = 2'b00;
      step(2'b00, 4'b1010, 1'b1, 1'b1, "R1 idle after reset");

      // R2 loads
      step(2'b11, 4'b1010, 1'b0, 1'b0, "R2");
      step(2'b11, 4'b0101, 1'b1, 1'b1, "R2");
      step(2'b11, 4'b1110, 1'b0, 1'b1, "R2");

      // R3 upward shifts
      step(2'b01, 4'b0000, 1'b1, 1'b0, "R3");
      step(2'b01, 4'b1111, 1'b0, 1'b1, "R3");
      step(2'b01, 4'b0000, 1'b1, 1'b0, "R3");

      // R4 downward shifts
      step(2'b10, 4'b0000, 1'b0, 1'b1, "R4");
      step(2'b10, 4'b1111, 1'b1, 1'b0, "R4");
      step(2'b10, 4'b0000, 1'b0, 1'b1, "R4");

      // R5 hold with noisy inputs
      step(2'b00, 4'b1111, 1'b1, 1'b1, "R5");
      step(2'b00, 4'b0000, 1'b0, 1'b0, "R5");
      step(2'b00, 4'b1001, 1'b1, 0,    "R5");

      // R7 mode changes on every edge
      step(2'b11, 4'b0110, 1'b0, 1'b0, "R7 load");
      step(2'b01, 4'b0000, 1'b1, 1'b0, "R7 up");
      step(2'b10, 4'b0000, 1'b0, 1'b0, "R7 down");
      step(2'b00, 4'b1111, 1'b1, 1'b1, "R7 hold");
      step(2'b11, 4'b1001, 1'b0, 1'b0, "R7 load");

      // R8 serial latency upward
      step(2'b11, 4'b0000, 1'b0, 1'b0, "R8 preload");
      step(2'b01, 4'b0000, 1'b1, 1'b0, "R8 up1");
      step(2'b01, 4'b0000, 1'b0, 1'b0, "R8 up2");
      step(2'b01, 4'b0000, 1'b0, 1'b0, "R8 up3");
      step(2'b01, 4'b0000, 1'b0, 1'b0, "R8 up4");
      @(negedge clk); mode = 2'b00;
      total++;
      if (q[W-1] !== 1'b1) begin bad++; $display("FAIL R8: q[top]=%b expected 1", q[W-1]); end
      // R8 serial latency downward
      step(2'b11, 4'b0000, 1'b0, 1'b0, "R8 preload");
      step(2'b10, 4'b0000, 1'b0, 1'b1, "R8 dn1");
      step(2'b10, 4'b0000, 1'b0, 1'b0, "R8 dn2");
      step(2'b10, 4'b0000, 1'b0, 1'b0, "R8 dn3");
      step(2'b10, 4'b0000, 1'b0, 1'b0, "R8 dn4");
      @(negedge clk); mode = 2'b00;
      total++;
      if (q[0] !== 1'b1) begin bad++; $display("FAIL R8: q[0]=%b expected 1", q[0]); end

      // R6 asynchronous clear overriding load
      step(2'b11, 4'b1111, 1'b0, 1'b0, "R6 preload");
      @(negedge clk); mode = 2'b11; d = 4'b1011;
      @(posedge clk); #1;
      check(q, 4'b1011, "R6 loaded");
      #1 clr_n = 1'b0;
      #1 check(q, 4'b0000, "R6 async");
      @(posedge clk); #1;
      check(q, 4'b0000, "R6 clear beats load");
      @(negedge clk); clr_n = 1'b1; mode = 2'b00; model = '0;
      step(2'b00, 4'b1111, 1'b1, 1'b1, "R6 after release");
      @(posedge clk); #3;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule